// File: doc/BRIEF.md
# Grouped-Priority Channel Arbiter

The arbiter decides which of up to 32 DMA channels that have work pending gets the shared memory bus next. Each channel falls into one of four priority levels, and the level comes from bits [3:2] of the channel's index. The upper sixteen channels therefore repeat the level pattern of the lower sixteen rather than continuing a flat order. The highest level with any requester wins. Inside that level, the requesting channel with the smallest index wins.

A grant is registered. It stays fixed, as a one-hot vector and as a binary index, until the granted engine pulses `done`. The grant then drops for one cycle, and a new choice is made in the cycle after that. Alongside the grant, the block registers the channel engines' interrupt lines into one status word with a bit per channel. It also raises a summary flag when any bit of that word is set.

Top module: `grp_prio_arb`

## Requirements
- R1: After reset, `gnt_vld` is 0, `gnt` is all zeros, `gnt_idx` is 0 and `irq_status` is all zeros.
- R2: Channel i has level ((i / 4) mod 4), which is index bits [3:2] when the parameters take their defaults. Level 0 is the highest. A requester in a lower-numbered level always wins over any requester in a higher-numbered level, whatever their indices. For example, channel 16 (level 0) beats channel 4 (level 1), and channel 8 (level 2) beats channels 12 and 28 (level 3).
- R3: When several requesters share the winning level, the one with the smallest index is granted. For example, 3 beats 17, and 17 beats 19.
- R4: When no grant is held and at least one channel is requesting at a rising clock edge, `gnt_vld` is 1 after that edge.
- R5: While a grant is held and `done` is 0, `gnt_idx` and `gnt` do not change, even when the request vector changes.
- R6: `done` at 1 while a grant is held makes `gnt_vld` 0 after that edge. The next grant is decided at the following edge, from the requests present at that edge.
- R7: When no grant is held, `gnt` is all zeros. If no channel requests, `gnt_vld` stays 0.
- R8: While `gnt_vld` is 1, `gnt` has exactly one bit set, at position `gnt_idx`.
- R9: `irq_status` equals the value `irq_src` had at the previous rising edge. `irq_any` is 1 exactly when some bit of `irq_status` is 1.
- R10: A `done` pulse while no grant is held has no effect: `gnt_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NUM_CH | Per-channel request |
| done | input | 1 | Granted channel finished its transfer |
| irq_src | input | NUM_CH | Per-channel pending interrupt from the engines |
| gnt | output | NUM_CH | One-hot grant |
| gnt_idx | output | IDX_W | Index of the granted channel |
| gnt_vld | output | 1 | A grant is held |
| irq_status | output | NUM_CH | Registered interrupt status word |
| irq_any | output | 1 | OR of all status bits |

## Verification
The hardest case to reach is the handover. A grant finishes while another channel is still requesting, and the choice must wait one idle cycle and then select the remaining requester. The stimulus keeps two requesters active across the `done` pulse and withdraws the finished one on the same edge. It then checks the idle cycle and the next grant. A second hard case is the grant holding still while the requests change. To test it, the bench raises every request line, channel 0 included, while a grant is held, and confirms the index does not move.

// File: rtl/grp_prio_arb.sv
module grp_prio_arb #(
  parameter int NUM_CH   = 32,
  parameter int GRP_SIZE = 4,
  parameter int LEVELS   = 4,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              done,
  input  logic [NUM_CH-1:0] irq_src,
  output logic [NUM_CH-1:0] gnt,
  output logic [IDX_W-1:0]  gnt_idx,
  output logic              gnt_vld,
  output logic [NUM_CH-1:0] irq_status,
  output logic              irq_any
);

  logic             win_found;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (!win_found && req[i] && ((i / GRP_SIZE) % LEVELS) == l) begin
          win_found = 1'b1;
          win_idx   = IDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld <= 1'b0;
      gnt_idx <= '0;
    end else if (gnt_vld) begin
      if (done) gnt_vld <= 1'b0;
    end else if (win_found) begin
      gnt_vld <= 1'b1;
      gnt_idx <= win_idx;
    end
  end

  assign gnt = gnt_vld ? (NUM_CH'(1) << gnt_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_status <= '0;
    else        irq_status <= irq_src;
  end

  assign irq_any = |irq_status;

  AST_IDLE_TAKES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && (|req)) |=> gnt_vld); // R4
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !done) |=> (gnt_vld && $stable(gnt_idx))); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && done) |=> !gnt_vld); // R6
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && !(|req)) |=> !gnt_vld); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (gnt == '0)); // R7
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ($countones(gnt) == 1 && gnt[gnt_idx])); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_status == $past(irq_src))); // R9

endmodule

// File: tb/tb_grp_prio_arb.sv
`timescale 1ns/1ps
module tb_grp_prio_arb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         done = 1'b0;
  logic [N-1:0] irq_src = '0;
  logic [N-1:0] gnt;
  logic [4:0]   gnt_idx;
  logic         gnt_vld;
  logic [N-1:0] irq_status;
  logic         irq_any;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  logic prev_vld = 1'b0;

  always #2.5 clk = ~clk;

  grp_prio_arb dut (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .irq_src(irq_src),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld),
    .irq_status(irq_status), .irq_any(irq_any)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt_vld && !prev_vld) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R3 unexpected grant", gnt_idx, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(gnt_idx == 5'(e), "R2/R3 winner", gnt_idx, e);
        end
      end
      prev_vld <= gnt_vld;
    end
  end

  task automatic serve(input logic [N-1:0] v, input int e);
    exp_q.push_back(e);
    req = v;
    @(negedge clk);
    chk(gnt_vld == 1'b1, "R4 grant taken", gnt_vld, 1);
    chk(gnt == (N'(1) << e), "R8 one-hot grant", gnt, N'(1) << e);
    req = '1;
    repeat (3) @(negedge clk);
    chk(gnt_idx == 5'(e) && gnt_vld, "R5 grant held", gnt_idx, e);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    req = '0;
    chk(gnt_vld == 1'b0, "R6 release after done", gnt_vld, 0);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gnt_vld == 1'b0, "R1 vld reset", gnt_vld, 0);
    chk(gnt == '0, "R1 gnt reset", gnt, 0);
    chk(gnt_idx == '0, "R1 idx reset", gnt_idx, 0);
    chk(irq_status == '0, "R1 status reset", irq_status, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(gnt_vld == 1'b0 && gnt == '0, "R7 idle without requests", gnt, 0);

    serve((N'(1) << 16) | (N'(1) << 4), 16);                 // R2
    serve((N'(1) << 28) | (N'(1) << 12) | (N'(1) << 8), 8);  // R2
    serve(N'(1) << 31, 31);                                  // R2
    serve((N'(1) << 3) | (N'(1) << 17), 3);                  // R3
    serve((N'(1) << 19) | (N'(1) << 17), 17);                // R3
    serve((N'(1) << 23) | (N'(1) << 7) | (N'(1) << 5), 5);   // R3

    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk(gnt_vld == 1'b0, "R10 done while idle ignored", gnt_vld, 0);

    exp_q.push_back(5);
    exp_q.push_back(9);
    req = (N'(1) << 5) | (N'(1) << 9);
    @(negedge clk);
    chk(gnt_idx == 5'd5, "R6 first of pair", gnt_idx, 5);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    req = N'(1) << 9;
    chk(gnt_vld == 1'b0, "R6 idle cycle between grants", gnt_vld, 0);
    @(negedge clk);
    chk(gnt_vld == 1'b1 && gnt_idx == 5'd9, "R6 next grant", gnt_idx, 9);
    done = 1'b1;
    req = '0;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk(gnt_vld == 1'b0, "R7 idle after pair", gnt_vld, 0);

    irq_src = 32'h8001_0420;
    @(negedge clk);
    chk(irq_status == 32'h8001_0420, "R9 status word", irq_status, 32'h8001_0420);
    chk(irq_any == 1'b1, "R9 any set", irq_any, 1);
    irq_src = '0;
    @(negedge clk);
    chk(irq_status == '0 && irq_any == 1'b0, "R9 cleared", irq_any, 0);

    chk(exp_q.size() == 0, "R4 all expected grants seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule